// File: doc/BRIEF.md
# Output Impedance Calibration Sequencer

This block is the digital control loop that trims a programmable output driver toward a target impedance. A free-running cycle counter fires an evaluation once per fixed period and then starts counting again. At each evaluation the block looks at a comparator indication, after passing it through a synchronizer. The indication says whether the driver is too weak or too strong. The block then moves a binary-weighted strength code by exactly one step in the direction that brings the driver closer to the reference. The code never wraps around. It stops at the bottom and at the top of its range.

After reset the code starts at mid-scale. Trimming begins at once, and it goes on for as long as the block is clocked, so that the driver keeps tracking drift in supply and temperature. A separate start-up counter runs on every clock cycle, whatever else the device is doing. Once its fixed window has elapsed it raises a ready flag, and the flag stays high until the next reset.

Top module: `drv_imp_cal`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the code equals mid-scale (2^(CODE_W-1), 32 for the default 6-bit width), and eval_o and ready_o are both low.
- R2: eval_o is high for exactly one cycle in every EVAL_PERIOD cycles. Counting rising edges after reset release as 1, 2, 3 and so on, the pulse follows edges EVAL_PERIOD, 2*EVAL_PERIOD, and so on.
- R3: The code changes only on the edge that raises eval_o, and it holds its value between evaluations.
- R4: At each evaluation the code rises by one when the synchronized comparator value is 1 (driver too weak) and falls by one when it is 0 (driver too strong).
- R5: The code saturates at 0 and at 2^CODE_W-1 (63 by default), with no wraparound.
- R6: The comparator input passes through a two-flop synchronizer. A change that arrives less than two full cycles before an evaluation edge does not affect that evaluation.
- R7: ready_o rises after exactly STARTUP_CYCLES rising edges following reset release (32768 by default) and then stays high. Evaluations continue both before and after ready_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_up_i | input | 1 | Comparator result: 1 = driver too weak (step up), 0 = too strong (step down) |
| imp_code_o | output | CODE_W | Binary-weighted driver strength code |
| eval_o | output | 1 | One-cycle evaluation strobe |
| ready_o | output | 1 | Start-up window elapsed |

## Verification
The properties assume that the comparator input is a level, which may change at any time, and that EVAL_PERIOD is greater than two, so that one strobe ends before the next begins. The stimulus changes the comparator value half a cycle after each strobe, which gives the synchronizer a full period to settle. On one chosen interval it adds a late opposite flip only one and a half cycles before the next evaluation edge. That flip exercises the latency boundary without leaving the assumed input behaviour. The bench shortens the period and the start-up window through parameters, so that both saturation limits and the ready transition fall inside the run.

// File: rtl/imp_cal_pkg.sv
package imp_cal_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_dir_e;

    function automatic step_dir_e pick_dir(input logic fire, input logic up);
        if (!fire) begin
            return STEP_HOLD;
        end
        return up ? STEP_UP : STEP_DOWN;
    endfunction

endpackage

// File: rtl/imp_cal_sync.sv
module imp_cal_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t state_d, state_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb state_d.chain[g] = async_i;
        end else begin : g_rest
            always_comb state_d.chain[g] = state_q.chain[g-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sync_o = state_q.chain[STAGES-1];
endmodule

// File: rtl/imp_cal_timer.sv
module imp_cal_timer #(
    parameter int unsigned PERIOD = 1024
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic fire_o,
    output logic strobe_o
);
    localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             strobe;
    } timer_state_t;

    timer_state_t state_d, state_q;
    logic         wrap;

    always_comb begin
        state_d = state_q;
        wrap    = (state_q.cnt == LAST);
        if (wrap) begin
            state_d.cnt = '0;
        end else begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
        state_d.strobe = wrap;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign fire_o   = wrap;
    assign strobe_o = state_q.strobe;
endmodule

// File: rtl/imp_cal_startup.sv
module imp_cal_startup #(
    parameter int unsigned WINDOW = 32768
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic ready_o
);
    localparam int unsigned CNT_W = $clog2(WINDOW + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ready;
    } start_state_t;

    start_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (!state_q.ready) begin
            state_d.cnt = state_q.cnt + 1'b1;
            if (state_q.cnt == LAST) begin
                state_d.ready = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ready_o = state_q.ready;
endmodule

// File: rtl/imp_cal_stepper.sv
module imp_cal_stepper
    import imp_cal_pkg::*;
#(
    parameter int unsigned CODE_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  step_dir_e         dir_i,
    output logic [CODE_W-1:0] code_o
);
    localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CODE_W-1:0] CODE_MIN = '0;

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } step_state_t;

    step_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case (dir_i)
            STEP_UP: begin
                if (state_q.code != CODE_MAX) begin
                    state_d.code = state_q.code + 1'b1;
                end
            end
            STEP_DOWN: begin
                if (state_q.code != CODE_MIN) begin
                    state_d.code = state_q.code - 1'b1;
                end
            end
            default: state_d.code = state_q.code;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.code <= CODE_MID;
        end else begin
            state_q <= state_d;
        end
    end

    assign code_o = state_q.code;
endmodule

// File: rtl/drv_imp_cal.sv
module drv_imp_cal
    import imp_cal_pkg::*;
#(
    parameter int unsigned CODE_W         = 6,
    parameter int unsigned EVAL_PERIOD    = 1024,
    parameter int unsigned STARTUP_CYCLES = 32768,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmp_up_i,
    output logic [CODE_W-1:0] imp_code_o,
    output logic              eval_o,
    output logic              ready_o
);
    logic      cmp_sync;
    logic      fire;
    step_dir_e dir;

    imp_cal_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (cmp_up_i),
        .sync_o  (cmp_sync)
    );

    imp_cal_timer #(.PERIOD(EVAL_PERIOD)) i_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .fire_o   (fire),
        .strobe_o (eval_o)
    );

    assign dir = pick_dir(fire, cmp_sync);

    imp_cal_stepper #(.CODE_W(CODE_W)) i_stepper (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .dir_i  (dir),
        .code_o (imp_code_o)
    );

    imp_cal_startup #(.WINDOW(STARTUP_CYCLES)) i_startup (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ready_o (ready_o)
    );
endmodule

// File: rtl/imp_cal_chk.sv
module imp_cal_chk #(
    parameter int unsigned CODE_W         = 6,
    parameter int unsigned STARTUP_CYCLES = 32768
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [CODE_W-1:0] imp_code_o,
    input logic              eval_o,
    input logic              ready_o
);
    localparam int unsigned WIN_W = $clog2(STARTUP_CYCLES + 1);
    localparam logic [CODE_W-1:0] TOP = '1;

    logic [WIN_W-1:0] seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_q <= '0;
        end else if (seen_q != WIN_W'(STARTUP_CYCLES)) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    assert_hold_between_evals_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (imp_code_o != $past(imp_code_o)) |-> eval_o);

    assert_single_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eval_o |-> ((imp_code_o == $past(imp_code_o) + 1'b1) ||
                    (imp_code_o == $past(imp_code_o) - 1'b1) ||
                    (imp_code_o == $past(imp_code_o))));

    assert_no_wrap_top_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(imp_code_o) == TOP) |-> (imp_code_o != '0));

    assert_no_wrap_bottom_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(imp_code_o) == '0) |-> (imp_code_o != TOP));

    assert_strobe_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eval_o |=> !eval_o);

    assert_ready_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o == (seen_q == WIN_W'(STARTUP_CYCLES)));

    assert_ready_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$fell(ready_o));
endmodule

bind drv_imp_cal imp_cal_chk #(
    .CODE_W         (CODE_W),
    .STARTUP_CYCLES (STARTUP_CYCLES)
) i_imp_cal_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .imp_code_o (imp_code_o),
    .eval_o     (eval_o),
    .ready_o    (ready_o)
);

// File: tb/test_drv_imp_cal.sv
module test_drv_imp_cal;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 6;
    localparam int PERIOD     = 16;
    localparam int STARTUP    = 512;
    localparam int N_OPS      = 126;
    localparam int LATE_OP    = 115;
    localparam int MAXC       = (1 << CODE_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmp_up = 1'b1;
    logic [CODE_W-1:0] code;
    logic              eval;
    logic              ready;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    drv_imp_cal #(
        .CODE_W         (CODE_W),
        .EVAL_PERIOD    (PERIOD),
        .STARTUP_CYCLES (STARTUP)
    ) i_drv_imp_cal (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .cmp_up_i   (cmp_up),
        .imp_code_o (code),
        .eval_o     (eval),
        .ready_o    (ready)
    );

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic bit op_dir(input int i);
        if (i < 40) return 1'b1;
        if (i < 110) return 1'b0;
        return i[0];
    endfunction

    // Monitor: compares code at each strobe against the scoreboard queue.
    initial begin : monitor
        int prev;
        int e;
        prev = 32;
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (done) break;
            check("R2 strobe", eval, (cyc > 0 && cyc % PERIOD == 0) ? 1 : 0);
            check("R7 ready", ready, (cyc >= STARTUP) ? 1 : 0);
            if (eval) begin
                if (exp_q.size() == 0) begin
                    check("R4 queue empty", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check("R4 R5 R6 code at eval", code, e);
                end
            end else begin
                check("R3 code hold", code, prev);
            end
            prev = code;
        end
    end

    // Driver: applies comparator values and pushes the expected code.
    initial begin : driver
        int expc;
        bit d;
        expc = 32;
        repeat (4) @(negedge clk);
        check("R1 reset code", code, 32);
        check("R1 reset eval", eval, 0);
        check("R1 reset ready", ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first cycle code", code, 32);
        check("R1 first cycle ready", ready, 0);
        for (int i = 0; i < N_OPS; i++) begin
            d = op_dir(i);
            cmp_up = d;
            if (d) expc = (expc == MAXC) ? MAXC : expc + 1;
            else   expc = (expc == 0) ? 0 : expc - 1;
            exp_q.push_back(expc);
            if (i == LATE_OP) begin
                // R6: late flip 1.5 cycles before the eval edge is ignored
                do @(negedge clk); while ((cyc % PERIOD) != PERIOD - 2);
                cmp_up = ~d;
            end
            do @(negedge clk); while (!eval);
        end
        check("R5 final code", code, expc);
        check("R7 ready held", ready, 1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule